// File: doc/BRIEF.md
# Refresh Debt Scheduler with Postpone and Pull-In Limits

This block decides when a DRAM controller should issue a refresh. Instead of refreshing on every interval, it keeps a signed refresh balance. A periodic interval tick adds one owed refresh, and each refresh that the command path accepts removes one. A positive balance is a debt of postponed refreshes. A negative balance is a credit of refreshes issued early.

Traffic is reported on a busy input. With postponement enabled, refreshes are held back while traffic is busy, so the data path keeps the bus. Once the debt reaches a programmable panic threshold, the owed refreshes are streamed back to back whatever the traffic, until the debt falls to a programmable floor. While the bus is idle, owed refreshes above that floor are let out. With pull-in enabled, refreshes are also issued ahead of time during idle periods, until a programmable credit limit is reached. A manual mode leaves refresh entirely to outside logic.

The block hands each refresh to the command path through a request and acknowledge pair. Precharge sequencing and refresh timing belong to the command path.

Top module: `rfsh_debt_sched`

## Requirements
- R1: After reset, `req_o` is low and the balance is zero, so with every mode off and no tick no request appears.
- R2: Each cycle with `tick_i` high adds 1 to the balance. Each cycle with `req_o` and `ack_i` both high subtracts 1. A tick and an accepted refresh in the same cycle leave the balance unchanged. `ack_i` while `req_o` is low has no effect.
- R3: `req_o` rises one clock edge after the cycle in which the conditions for a refresh hold. It stays high until a cycle with `ack_i` high, and is low in the cycle after that. A new request comes no sooner than one cycle later.
- R4: With postponement off, a request is made whenever the balance is above zero, even while `busy_i` is high.
- R5: With postponement on and `busy_i` high, no owed refresh is requested while the balance is below `upper_i` and no stream is in progress.
- R6: With postponement on, a balance reaching `upper_i` starts a stream of requests regardless of `busy_i`. The stream continues until the balance falls to `lower_i`.
- R7: With postponement on and `busy_i` low, a request is made while the balance is above `lower_i`, and none while it equals `lower_i`.
- R8: With pull-in on and `busy_i` low, requests continue while the balance is above minus `prepay_i`. While `busy_i` is high, no refresh is pulled in.
- R9: While `manual_i` is high, no new request is made, `ack_i` is ignored and the balance is forced to zero, so no owed refresh remains when manual mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Refresh-interval tick, one cycle per interval |
| busy_i | input | 1 | High while normal traffic occupies the bus |
| postpone_en_i | input | 1 | Allows owed refreshes to be deferred |
| pullin_en_i | input | 1 | Allows refreshes ahead of schedule when idle |
| manual_i | input | 1 | Refresh is controlled from outside; the scheduler stays silent |
| lower_i | input | LIM_W | Debt floor at which streaming stops |
| upper_i | input | LIM_W | Debt at which panic streaming starts |
| prepay_i | input | LIM_W | Largest credit of early refreshes |
| ack_i | input | 1 | Command path has taken the refresh |
| req_o | output | 1 | Refresh request, held until acknowledged |

## Verification
An interval tick and an accepted refresh can land in the same cycle, so the balance update must combine an increment and a decrement. The bench provokes this by raising `tick_i` and `ack_i` together while a request is pending, with postponement off and traffic busy. It judges the result by counting the refreshes requested afterwards: exactly one more means the balance stayed at one, while zero or two would show that one of the two updates was lost. A second case pulses `ack_i` with no request pending, then ticks once, and expects exactly one request.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef struct packed {
      logic inc;
      logic dec;
   } bal_step_t;

   function automatic logic signed [1:0] step_delta(input bal_step_t s);
      logic signed [1:0] d;
      case ({s.inc, s.dec})
         2'b10:   d = 2'sb01;
         2'b01:   d = 2'sb11;
         default: d = 2'sb00;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/rfsh_balance.sv
module rfsh_balance
   import rfsh_pkg::*;
#(
   parameter int BW     = 10,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  bal_step_t            step,
   output logic signed [BW-1:0] bal
);

   logic signed [1:0]  delta;
   logic signed [BW:0] sum;
   logic signed [BW-1:0] nxt;

   assign delta = step_delta(step);
   assign sum   = {bal[BW-1], bal} + {{(BW-1){delta[1]}}, delta};

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            if (sum[BW] != sum[BW-1])
               nxt = sum[BW] ? {1'b1, {(BW-1){1'b0}}} : {1'b0, {(BW-1){1'b1}}};
            else
               nxt = sum[BW-1:0];
         end
      end else begin : g_wrap
         assign nxt = sum[BW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bal <= '0;
      else if (clear) bal <= '0;
      else            bal <= nxt;
   end

endmodule

// File: rtl/rfsh_policy.sv
module rfsh_policy #(
   parameter int LW          = 8,
   parameter int BW          = LW + 2,
   parameter bit PREPAY_IMPL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [BW-1:0] bal,
   input  logic                 busy,
   input  logic                 postpone_en,
   input  logic                 pullin_en,
   input  logic                 manual,
   input  logic [LW-1:0]        lower,
   input  logic [LW-1:0]        upper,
   input  logic [LW-1:0]        prepay,
   output logic                 want
);

   localparam int PAD = BW - LW;

   logic signed [BW-1:0] lo_s, hi_s, pre_floor;
   logic panic_q, stream, owed_direct, owed_idle, early;

   assign lo_s = $signed({{PAD{1'b0}}, lower});
   assign hi_s = $signed({{PAD{1'b0}}, upper});

   assign stream = !manual && postpone_en && (panic_q || (bal >= hi_s)) && (bal > lo_s);

   assign owed_direct = !postpone_en && (bal > 0);
   assign owed_idle   = postpone_en && !busy && (bal > lo_s);

   generate
      if (PREPAY_IMPL) begin : g_prepay
         assign pre_floor = -$signed({{PAD{1'b0}}, prepay});
         assign early     = pullin_en && !busy && (bal > pre_floor);
      end else begin : g_noprepay
         logic unused_pre;
         assign unused_pre = pullin_en ^ (^prepay);
         assign pre_floor  = '0;
         assign early      = 1'b0;
      end
   endgenerate

   assign want = !manual && (owed_direct || stream || owed_idle || early);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) panic_q <= 1'b0;
      else        panic_q <= stream;
   end

endmodule

// File: rtl/rfsh_req_hs.sv
module rfsh_req_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic ack,
   output logic req,
   output logic take
);

   assign take = req && ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          req <= 1'b0;
      else if (take)       req <= 1'b0;
      else if (!req && want) req <= 1'b1;
   end

endmodule

// File: rtl/rfsh_debt_sched.sv
module rfsh_debt_sched
   import rfsh_pkg::*;
#(
   parameter int LIM_W       = 8,
   parameter bit SAT_EN      = 1'b1,
   parameter bit PREPAY_IMPL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             busy_i,
   input  logic             postpone_en_i,
   input  logic             pullin_en_i,
   input  logic             manual_i,
   input  logic [LIM_W-1:0] lower_i,
   input  logic [LIM_W-1:0] upper_i,
   input  logic [LIM_W-1:0] prepay_i,
   input  logic             ack_i,
   output logic             req_o
);

   localparam int BAL_W = LIM_W + 2;

   generate
      if (LIM_W < 2) begin : g_bad_lim
         $error("rfsh_debt_sched: LIM_W must be at least 2");
      end
      if (LIM_W > 30) begin : g_big_lim
         $error("rfsh_debt_sched: LIM_W must not exceed 30");
      end
   endgenerate

   logic signed [BAL_W-1:0] bal_q;
   bal_step_t step;
   logic want, take;

   assign step.inc = tick_i;
   assign step.dec = take && !manual_i;

   rfsh_balance #(.BW(BAL_W), .SAT_EN(SAT_EN)) u_bal (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (manual_i),
      .step  (step),
      .bal   (bal_q)
   );

   rfsh_policy #(.LW(LIM_W), .BW(BAL_W), .PREPAY_IMPL(PREPAY_IMPL)) u_pol (
      .clk         (clk),
      .rst_n       (rst_n),
      .bal         (bal_q),
      .busy        (busy_i),
      .postpone_en (postpone_en_i),
      .pullin_en   (pullin_en_i),
      .manual      (manual_i),
      .lower       (lower_i),
      .upper       (upper_i),
      .prepay      (prepay_i),
      .want        (want)
   );

   rfsh_req_hs u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want),
      .ack   (ack_i),
      .req   (req_o),
      .take  (take)
   );

endmodule

// File: rtl/rfsh_debt_sched_chk.sv
module rfsh_debt_sched_chk #(
   parameter int BW = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_i,
   input logic                 ack_i,
   input logic                 busy_i,
   input logic                 manual_i,
   input logic                 req_o,
   input logic signed [BW-1:0] bal
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> req_o); // R3

   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i) |=> !req_o); // R3

   AST_MANUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (manual_i && !req_o) |=> !req_o); // R9

   AST_BUSY_NO_PULLIN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !req_o && (bal <= 0)) |=> !req_o); // R8

   AST_TICK_ACK_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && req_o && ack_i && !manual_i) |=> (bal == $past(bal))); // R2

   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!manual_i && (bal > -(2 ** (BW - 2))) && (bal < (2 ** (BW - 2))))
      |=> ((bal == $past(bal)) || (bal == $past(bal) + 1) || (bal == $past(bal) - 1))); // R2

endmodule

bind rfsh_debt_sched rfsh_debt_sched_chk #(.BW(BAL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_i   (tick_i),
   .ack_i    (ack_i),
   .busy_i   (busy_i),
   .manual_i (manual_i),
   .req_o    (req_o),
   .bal      (bal_q)
);

// File: tb/rfsh_debt_sched_bench.sv
`timescale 1ns/1ps
module rfsh_debt_sched_bench;

   localparam int LW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0, busy_i = 1'b0, postpone_en_i = 1'b0, pullin_en_i = 1'b0;
   logic manual_i = 1'b0, ack_i = 1'b0;
   logic [LW-1:0] lower_i = '0, upper_i = '0, prepay_i = '0;
   logic req_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rfsh_debt_sched #(.LIM_W(LW)) u_rfsh_debt_sched (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_i),
      .postpone_en_i(postpone_en_i), .pullin_en_i(pullin_en_i), .manual_i(manual_i),
      .lower_i(lower_i), .upper_i(upper_i), .prepay_i(prepay_i),
      .ack_i(ack_i), .req_o(req_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      tick_i = 0; busy_i = 0; postpone_en_i = 0; pullin_en_i = 0;
      manual_i = 0; ack_i = 0; lower_i = 0; upper_i = 0; prepay_i = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic pulse_tick();
      tick_i = 1;
      @(negedge clk);
      tick_i = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(output int cnt);
      int quiet;
      cnt = 0;
      quiet = 0;
      while (quiet < 6) begin
         @(negedge clk);
         if (req_o) begin
            ack_i = 1;
            @(negedge clk);
            ack_i = 0;
            cnt++;
            quiet = 0;
         end else begin
            quiet++;
         end
      end
   endtask

   task automatic t_reset();
      int cnt;
      do_reset();
      check("R1 req low after reset", int'(req_o), 0);
      drain(cnt);
      check("R1 no request from zero balance", cnt, 0);
   endtask

   task automatic t_direct();
      do_reset();
      busy_i = 1;
      pulse_tick();
      check("R3 no request in tick cycle+1", int'(req_o), 0);
      @(negedge clk);
      check("R4 request while busy, postpone off", int'(req_o), 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R3 request held without ack", int'(req_o), 1);
      end
      ack_i = 1;
      @(negedge clk);
      ack_i = 0;
      check("R3 request drops after ack", int'(req_o), 0);
      idle(4);
      check("R4 no request at zero balance", int'(req_o), 0);
   endtask

   task automatic t_defer();
      int cnt;
      do_reset();
      postpone_en_i = 1; lower_i = 1; upper_i = 4; busy_i = 1;
      for (int i = 0; i < 3; i++) pulse_tick();
      drain(cnt);
      check("R5 busy defers below upper", cnt, 0);
      pulse_tick();
      drain(cnt);
      check("R6 panic stream down to lower", cnt, 3);
      busy_i = 0;
      drain(cnt);
      check("R7 idle at lower makes no request", cnt, 0);
      pulse_tick();
      drain(cnt);
      check("R7 idle above lower requests", cnt, 1);
   endtask

   task automatic t_prepay();
      int cnt;
      do_reset();
      pullin_en_i = 1; prepay_i = 3; busy_i = 1;
      drain(cnt);
      check("R8 no pull-in while busy", cnt, 0);
      busy_i = 0;
      drain(cnt);
      check("R8 pull-in up to prepay limit", cnt, 3);
      pulse_tick();
      drain(cnt);
      check("R8 one more after tick restores credit room", cnt, 1);
   endtask

   task automatic t_same_cycle();
      int cnt;
      do_reset();
      busy_i = 1;
      pulse_tick();
      @(negedge clk);
      check("R3 request pending before overlap", int'(req_o), 1);
      tick_i = 1; ack_i = 1;
      @(negedge clk);
      tick_i = 0; ack_i = 0;
      drain(cnt);
      check("R2 tick with ack leaves balance one", cnt, 1);
   endtask

   task automatic t_stray_ack();
      int cnt;
      do_reset();
      busy_i = 1;
      ack_i = 1;
      @(negedge clk);
      ack_i = 0;
      pulse_tick();
      drain(cnt);
      check("R2 ack without request ignored", cnt, 1);
   endtask

   task automatic t_manual();
      int cnt;
      do_reset();
      manual_i = 1; pullin_en_i = 1; prepay_i = 2;
      for (int i = 0; i < 3; i++) pulse_tick();
      ack_i = 1;
      @(negedge clk);
      ack_i = 0;
      drain(cnt);
      check("R9 no request in manual mode", cnt, 0);
      pullin_en_i = 0;
      manual_i = 0;
      drain(cnt);
      check("R9 balance cleared by manual mode", cnt, 0);
   endtask

   initial begin
      t_reset();
      t_direct();
      t_defer();
      t_prepay();
      t_same_cycle();
      t_stray_ack();
      t_manual();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule